// File: doc/BRIEF.md
# Serial Bit-Addressed I/O Unit

This block runs an I/O bus on which every peripheral input and every peripheral output is one addressable bit. On the processor side it takes one command at a time. A command carries an operation, a software base register, an 8-bit argument and a data word. The unit raises `busy` while it works and pulses `done` when the result is ready. On the bus side it drives a 12-bit bit address, a data bit and a write strobe, and it reads one input bit back from the addressed peripheral.

There are three single-bit operations: set, clear and test. Each one addresses the bus at the base plus a signed displacement. Test returns the addressed input bit, so software can poll a ready flag. The two multi-bit operations move between 1 and 16 bits serially, least significant bit first, one bit per clock, at consecutive addresses starting at the base:

- load-out sends bits from the data word onto the bus;
- store-in gathers bus bits into a result word.

Top module: `sbio_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `io_wstrobe`, `rsp_bit` and `rsp_data` are all zero.
- R2: A command is accepted on a clock edge where `cmd_valid` is high, `busy` is low and `cmd_op` is 0 to 4. Op codes 5, 6 and 7 are never accepted: `busy` stays low and no strobe follows.
- R3: For single-bit operations, the bus address is `cmd_base[12:1]` plus `cmd_arg` read as a signed 8-bit value, wrapped to 12 bits.
- R4: Set (op 0) and clear (op 1) each produce exactly one strobe cycle at the R3 address, with `io_dout` equal to 1 for set and 0 for clear.
- R5: Test (op 2) reads `io_din` at the R3 address without any strobe. The bit read appears on `rsp_bit` in the cycle `done` is high.
- R6: For multi-bit operations, the bit count is `cmd_arg[3:0]`, where 0 means 16. The first bit goes to address `cmd_base[12:1]`, with no displacement. The address rises by one on each following clock.
- R7: Load-out (op 3) strobes every bit. Bit i on the bus is `cmd_data[i]` when the count is above 8, and `cmd_data[8+i]` when the count is 8 or less.
- R8: Store-in (op 4) never strobes. When `done` is high, `rsp_data` holds the bit read at address start+i in position i (count above 8) or in position 8+i (count 8 or less). Every other bit of `rsp_data` is zero.
- R9: An N-bit command keeps `busy` high for exactly N cycles, starting the cycle after acceptance. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R10: A command offered while `busy` is high has no effect on the running transfer.
- R11: `io_wstrobe` is high only while `busy` is high, and only for set, clear and load-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | 0 set, 1 clear, 2 test, 3 load-out, 4 store-in |
| cmd_base | input | 16 | Software base register; bits 12:1 form the bit base |
| cmd_arg | input | 8 | Signed displacement (ops 0-2) or bit count in bits 3:0 (ops 3-4) |
| cmd_data | input | 16 | Word to send for load-out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_bit | output | 1 | Bit read by the last test |
| rsp_data | output | 16 | Word assembled by the last store-in |
| io_addr | output | 12 | Bus bit address |
| io_dout | output | 1 | Bus output bit |
| io_wstrobe | output | 1 | Bus write strobe, one cycle per bit written |
| io_din | input | 1 | Bus input bit from the addressed peripheral |

## Verification
The bus side makes every internal fault visible within the command that exposes it. A wrong address counter or a wrong displacement sign shows up on `io_addr` in the first or the following bus cycle. A wrong remaining-bit count changes the length of the `busy` window by the time the transfer ends. A wrong byte/word selection or a wrong capture position shows up as a bad `io_dout` bit, or as a bad `rsp_data` bit in the `done` cycle. The bench drives `io_din` from a varying function of the address, so a wrong capture position produces a wrong bit.

// File: rtl/sbio_pkg.sv
package sbio_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int DISP_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_SET   = 3'd0,
        OP_CLR   = 3'd1,
        OP_TEST  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] start;
        logic [CNT_W:0]    nbits;
        logic              byte_sel;
    } xfer_t;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op == OP_SET) || (op == OP_CLR) || (op == OP_LOAD);
    endfunction

    function automatic logic op_multi(input op_e op);
        return (op == OP_LOAD) || (op == OP_STORE);
    endfunction

    // Base register with its low bit dropped, plus sign-extended displacement.
    function automatic logic [ADDR_W-1:0] bit_addr(input logic [DATA_W-1:0] base,
                                                    input logic [DISP_W-1:0] disp);
        logic [ADDR_W-1:0] ext;
        ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        return base[ADDR_W:1] + ext;
    endfunction

    function automatic logic [ADDR_W-1:0] base_addr(input logic [DATA_W-1:0] base);
        return base[ADDR_W:1];
    endfunction

    function automatic logic [CNT_W:0] field_width(input logic [CNT_W-1:0] f);
        return (f == '0) ? (CNT_W+1)'(DATA_W) : {1'b0, f};
    endfunction

endpackage

// File: rtl/sbio_addr_gen.sv
module sbio_addr_gen #(
    parameter int ADDR_W = sbio_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= start;
        else if (step) addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
endmodule

// File: rtl/sbio_bit_seq.sv
module sbio_bit_seq #(
    parameter int CNT_W = sbio_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W:0]   nbits,
    input  logic             step,
    output logic [CNT_W-1:0] idx,
    output logic             last
);
    logic [CNT_W:0]   rem_q;
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            rem_q <= nbits;
            idx_q <= '0;
        end else if (step) begin
            rem_q <= rem_q - 1'b1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign last = (rem_q == (CNT_W+1)'(1));
endmodule

// File: rtl/sbio_word_path.sv
module sbio_word_path #(
    parameter int DATA_W = sbio_pkg::DATA_W,
    parameter int CNT_W  = sbio_pkg::CNT_W,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear_acc,
    input  logic [DATA_W-1:0] src,
    input  logic              byte_sel,
    input  logic [CNT_W-1:0]  idx,
    input  logic              capture,
    input  logic              din,
    output logic              dout,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] acc_q;
    logic              byte_q;
    logic [CNT_W-1:0]  pos;

    // Short transfers use the upper half of the word.
    assign pos  = byte_q ? (idx + CNT_W'(HALF_W)) : idx;
    assign dout = src_q[pos];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            acc_q  <= '0;
            byte_q <= 1'b0;
        end else begin
            if (load) begin
                src_q  <= src;
                byte_q <= byte_sel;
            end
            if (load && clear_acc) acc_q      <= '0;
            else if (capture)      acc_q[pos] <= din;
        end
    end

    assign result = acc_q;
endmodule

// File: rtl/sbio_unit.sv
module sbio_unit
    import sbio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_base,
    input  logic [DISP_W-1:0] cmd_arg,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              rsp_bit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] io_addr,
    output logic              io_dout,
    output logic              io_wstrobe,
    input  logic              io_din
);
    logic              active_q;
    logic              done_q;
    logic              rsp_bit_q;
    xfer_t             cur_q;
    xfer_t             nxt;
    logic              accept;
    logic [DATA_W-1:0] src_word;
    logic [CNT_W-1:0]  idx;
    logic              last;
    logic              path_dout;
    logic              capture;

    assign accept = cmd_valid && !active_q && op_legal(cmd_op);

    always_comb begin
        nxt.op = op_e'(cmd_op);
        if (op_multi(nxt.op)) begin
            nxt.start    = base_addr(cmd_base);
            nxt.nbits    = field_width(cmd_arg[CNT_W-1:0]);
            nxt.byte_sel = (nxt.nbits <= (CNT_W+1)'(HALF_W));
        end else begin
            nxt.start    = bit_addr(cmd_base, cmd_arg);
            nxt.nbits    = (CNT_W+1)'(1);
            nxt.byte_sel = 1'b0;
        end
        case (nxt.op)
            OP_SET:  src_word = '1;
            OP_CLR:  src_word = '0;
            default: src_word = cmd_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            done_q    <= 1'b0;
            rsp_bit_q <= 1'b0;
            cur_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                active_q <= 1'b1;
                cur_q    <= nxt;
            end else if (active_q && last) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
            end
            if (active_q && cur_q.op == OP_TEST) rsp_bit_q <= io_din;
        end
    end

    sbio_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .start (nxt.start),
        .step  (active_q),
        .addr  (io_addr)
    );

    sbio_bit_seq #(.CNT_W(CNT_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .nbits (nxt.nbits),
        .step  (active_q),
        .idx   (idx),
        .last  (last)
    );

    assign capture = active_q && (cur_q.op == OP_STORE);

    sbio_word_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .clear_acc (nxt.op == OP_STORE),
        .src       (src_word),
        .byte_sel  (nxt.byte_sel),
        .idx       (idx),
        .capture   (capture),
        .din       (io_din),
        .dout      (path_dout),
        .result    (rsp_data)
    );

    assign busy       = active_q;
    assign done       = done_q;
    assign rsp_bit    = rsp_bit_q;
    assign io_wstrobe = active_q && op_writes(cur_q.op);
    assign io_dout    = io_wstrobe && path_dout;
endmodule

// File: rtl/sbio_checker.sv
module sbio_checker #(
    parameter int ADDR_W = sbio_pkg::ADDR_W,
    parameter int DATA_W = sbio_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wstrobe
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_q <= 0;
        else              run_q <= run_q + 1;
    end

    assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (rst)
        io_wstrobe |-> busy);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> io_addr == $past(io_addr) + 1'b1);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_fall_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_accept_legal_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cmd_valid) && $past(cmd_op) <= 3'd4));

    assert_run_bound_R9: assert property (@(posedge clk) disable iff (rst)
        run_q <= DATA_W);
endmodule

bind sbio_unit sbio_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .busy       (busy),
    .done       (done),
    .io_addr    (io_addr),
    .io_wstrobe (io_wstrobe)
);

// File: tb/sbio_unit_bench.sv
`timescale 1ns/1ps
module sbio_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_base;
    logic [7:0]  cmd_arg;
    logic [15:0] cmd_data;
    logic        busy, done, rsp_bit;
    logic [15:0] rsp_data;
    logic [11:0] io_addr;
    logic        io_dout, io_wstrobe, io_din;
    logic [11:0] din_mask;
    logic        din_inv;
    int          vectors = 0;
    int          errors  = 0;

    always #4 clk = ~clk;

    sbio_unit u_sbio_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_base(cmd_base), .cmd_arg(cmd_arg), .cmd_data(cmd_data),
        .busy(busy), .done(done), .rsp_bit(rsp_bit), .rsp_data(rsp_data),
        .io_addr(io_addr), .io_dout(io_dout), .io_wstrobe(io_wstrobe),
        .io_din(io_din)
    );

    function automatic logic din_at(input logic [11:0] a);
        return (^(a & din_mask)) ^ din_inv;
    endfunction

    assign io_din = din_at(io_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [15:0] base,
                           input logic [7:0] arg, input logic [15:0] data,
                           input bit flood);
        bit          multi = (op >= 3'd3);
        int          n     = multi ? ((arg[3:0] == 4'd0) ? 16 : int'(arg[3:0])) : 1;
        logic [11:0] start = multi ? base[12:1] : base[12:1] + {{4{arg[7]}}, arg};
        bit          bsel  = multi && (n <= 8);
        bit          wr    = (op == 3'd0) || (op == 3'd1) || (op == 3'd3);
        logic [15:0] exp_word = '0;
        logic        exp_bit  = 1'b0;
        int          cycles   = 0;
        string       areq     = multi ? "R6" : "R3";

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_base = base; cmd_arg = arg; cmd_data = data;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (!busy) begin
                cmd_valid = 1'b0;
                break;
            end
            if (flood) begin
                cmd_valid = 1'b1;
                cmd_op    = 3'($urandom_range(0, 4));
                cmd_base  = 16'($urandom);
                cmd_arg   = 8'($urandom);
                cmd_data  = 16'($urandom);
            end else begin
                cmd_valid = 1'b0;
            end
            if (cycles < 16) begin
                logic [11:0] ea  = start + 12'(cycles);
                int          pos = bsel ? cycles + 8 : cycles;
                check(io_addr == ea, areq, "bit address", 32'(io_addr), 32'(ea));
                check(io_wstrobe == wr, "R11", "strobe", 32'(io_wstrobe), 32'(wr));
                if (op == 3'd0) check(io_dout == 1'b1, "R4", "set data", 32'(io_dout), 1);
                if (op == 3'd1) check(io_dout == 1'b0, "R4", "clear data", 32'(io_dout), 0);
                if (op == 3'd3) check(io_dout == data[pos], "R7", "load-out bit",
                                      32'(io_dout), 32'(data[pos]));
                if (op == 3'd4) exp_word[pos] = din_at(ea);
                if (op == 3'd2) exp_bit = din_at(ea);
            end
            cycles++;
            if (cycles > 40) break;
        end
        cmd_valid = 1'b0;
        check(cycles == n, flood ? "R10" : "R9", "busy length", 32'(cycles), 32'(n));
        check(done == 1'b1, "R9", "done pulse", 32'(done), 1);
        if (op == 3'd2) check(rsp_bit == exp_bit, "R5", "test result", 32'(rsp_bit), 32'(exp_bit));
        if (op == 3'd4) check(rsp_data == exp_word, "R8", "store-in word", 32'(rsp_data), 32'(exp_word));
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", {done, busy}, 0);
    endtask

    task automatic try_illegal(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_base = 16'h0F0F; cmd_arg = 8'h05;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!busy && !io_wstrobe, "R2", "illegal op accepted", {busy, io_wstrobe}, 0);
        @(negedge clk);
        check(!busy && !done, "R2", "illegal op completed", {busy, done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_base = '0; cmd_arg = '0; cmd_data = '0;
        din_mask = 12'hA53; din_inv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !io_wstrobe && !rsp_bit && rsp_data == 16'h0,
              "R1", "reset state", {busy, done, io_wstrobe, rsp_bit}, 0);
        check(rsp_data == 16'h0, "R1", "reset rsp_data", 32'(rsp_data), 0);

        // Directed corners: displacement extremes and address wrap.
        run_cmd(3'd0, 16'h1FFE, 8'h7F, 16'h0, 1'b0);
        run_cmd(3'd1, 16'h0010, 8'h80, 16'h0, 1'b0);
        run_cmd(3'd2, 16'h0000, 8'hFF, 16'h0, 1'b0);
        din_inv = 1'b1;
        run_cmd(3'd2, 16'hE001, 8'h01, 16'h0, 1'b0);
        // Widths 0 (=16), 8, 9, 1.
        run_cmd(3'd3, 16'h0040, 8'h00, 16'hB6D3, 1'b0);
        run_cmd(3'd3, 16'h1FFC, 8'h08, 16'h5A3C, 1'b0);
        run_cmd(3'd3, 16'h0100, 8'h09, 16'hC3A5, 1'b0);
        run_cmd(3'd3, 16'h0100, 8'h01, 16'h8000, 1'b0);
        run_cmd(3'd4, 16'h1FF0, 8'h00, 16'h0, 1'b0);
        run_cmd(3'd4, 16'h0222, 8'h08, 16'h0, 1'b0);
        run_cmd(3'd4, 16'h0222, 8'h09, 16'h0, 1'b0);
        run_cmd(3'd4, 16'h0222, 8'h01, 16'h0, 1'b0);
        // Commands offered while busy.
        run_cmd(3'd3, 16'h0300, 8'h00, 16'h1234, 1'b1);
        run_cmd(3'd4, 16'h0300, 8'h0C, 16'h0, 1'b1);
        try_illegal(3'd5);
        try_illegal(3'd6);
        try_illegal(3'd7);

        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                din_mask = 12'($urandom);
                din_inv  = 1'($urandom);
            end
            run_cmd(3'($urandom_range(0, 4)), 16'($urandom), 8'($urandom),
                    16'($urandom), ($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule